// File: doc/BRIEF.md
# Link Recovery Rate-Upgrade Sequencer

This block steps a serial link through its recovery substates to move the link from one data rate to the other. The block starts in the active state. A rate-upgrade request sends it to receiver-lock. It then goes to receiver-configuration. If the training sets seen there negotiate a rate change, it enters the speed substate. On entry to the speed substate it flips the rate-select output toward the physical layer. It then makes a second pass through lock and configuration at the new rate, leaves through the idle substate, and returns to active. If the negotiation fails, configuration goes straight to idle and the rate is left unchanged.

The inputs are abstract flags from a receive decoder:
- symbol lock,
- a count of consecutive matching second-type training sets,
- the speed-change bit carried in those sets,
- idle data received,
- a timeout tick.

In any recovery substate, a timeout sends the machine back to receiver-lock at the rate that was in use when the request was made. A timeout also cancels the pending attempt, so each request tries a rate switch at most once.

Top module: `link_rate_seq`

## Requirements
- R1: After a synchronous active-high reset, `sub_state` is 000 (active), `rate_hi` is 0 and `send_ts2` is 0. The substate codes are: active 000, lock 001, config 010, speed 011, idle 100.
- R2: In active, `go_fast` moves the machine to lock on the next edge and arms one rate-switch attempt. Without `go_fast`, every other input has no effect and the machine stays in active.
- R3: In lock, with no timeout, `sym_lock` moves the machine to config on the next edge. `send_ts2` is 1 exactly while `sub_state` is config.
- R4: Config waits while `ts_run` is below MATCH_NEED (default 8). Config exits once `ts_run` reaches MATCH_NEED or more.
- R5: In config, if the count is met, `ts_spd` is 1 and an attempt is armed, the machine enters speed. On that same edge `rate_hi` inverts and the attempt is consumed.
- R6: Speed goes to lock on the next edge and keeps the new rate.
- R7: In config, if the count is met and either `ts_spd` is 0 or no attempt is armed, the machine goes to idle. The rate is unchanged and the attempt is cleared.
- R8: Idle goes to active on the edge after `idle_seen`. Otherwise it stays in idle.
- R9: `tmo` in any non-active substate takes priority over every exit condition. It moves the machine to lock, restores `rate_hi` to its value at the time of the request, and cancels the attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| go_fast | input | 1 | Rate-upgrade request, sampled in active |
| sym_lock | input | 1 | Symbol lock achieved |
| ts_run | input | CNT_W | Consecutive matching second-type training sets |
| ts_spd | input | 1 | Speed-change bit seen in those sets |
| idle_seen | input | 1 | Idle data received |
| tmo | input | 1 | Substate timeout tick |
| sub_state | output | 3 | Current substate code |
| rate_hi | output | 1 | Rate select toward the physical layer |
| send_ts2 | output | 1 | Transmit second-type training sets |

## Verification
Every substate move and every rate change shows up at the ports one edge after the inputs that cause it. `send_ts2` follows `sub_state` within the same cycle. The bench changes inputs one time unit after a rising edge and compares the outputs one time unit after the next rising edge, against a model it advances once per edge. Directed runs cover three cases: the full two-pass upgrade, a failed negotiation, and timeout fallbacks. A long pseudo-random sweep then compares every cycle and tags each check with the requirement that governs the transition the model took.

// File: rtl/link_rate_seq.sv
module link_rate_seq #(
  parameter int CNT_W      = 4,
  parameter int MATCH_NEED = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_fast,
  input  logic             sym_lock,
  input  logic [CNT_W-1:0] ts_run,
  input  logic             ts_spd,
  input  logic             idle_seen,
  input  logic             tmo,
  output logic [2:0]       sub_state,
  output logic             rate_hi,
  output logic             send_ts2
);

  localparam logic [2:0] S_ACT  = 3'd0;
  localparam logic [2:0] S_LOCK = 3'd1;
  localparam logic [2:0] S_CFG  = 3'd2;
  localparam logic [2:0] S_SPD  = 3'd3;
  localparam logic [2:0] S_IDLE = 3'd4;
  localparam logic [CNT_W-1:0] NEED = CNT_W'(MATCH_NEED);

  logic [2:0] st, st_nx;
  logic rate_nx, base_q, base_nx, pend_q, pend_nx;

  wire cnt_ok = ts_run >= NEED;

  always_comb begin
    st_nx   = st;
    rate_nx = rate_hi;
    base_nx = base_q;
    pend_nx = pend_q;
    if (tmo && st != S_ACT) begin
      st_nx   = S_LOCK;
      rate_nx = base_q;
      pend_nx = 1'b0;
    end else begin
      case (st)
        S_ACT:
          if (go_fast) begin
            st_nx   = S_LOCK;
            base_nx = rate_hi;
            pend_nx = 1'b1;
          end
        S_LOCK:
          if (sym_lock) st_nx = S_CFG;
        S_CFG:
          if (cnt_ok) begin
            pend_nx = 1'b0;
            if (ts_spd && pend_q) begin
              st_nx   = S_SPD;
              rate_nx = ~rate_hi;
            end else begin
              st_nx = S_IDLE;
            end
          end
        S_SPD:
          st_nx = S_LOCK;
        S_IDLE:
          if (idle_seen) st_nx = S_ACT;
        default:
          st_nx = S_ACT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_ACT;
      rate_hi <= 1'b0;
      base_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      st      <= st_nx;
      rate_hi <= rate_nx;
      base_q  <= base_nx;
      pend_q  <= pend_nx;
    end
  end

  assign sub_state = st;
  assign send_ts2  = (st == S_CFG);

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (rst)
    sub_state <= S_IDLE);

  assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (sub_state == S_ACT && !go_fast) |=> sub_state == S_ACT);

  assert_lock_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (sub_state == S_LOCK && sym_lock && !tmo) |=> sub_state == S_CFG);

  assert_cfg_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (sub_state == S_CFG && !tmo && ts_run < NEED) |=> sub_state == S_CFG);

  assert_speed_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (sub_state == S_CFG && !tmo && ts_run >= NEED && ts_spd && pend_q)
      |=> (sub_state == S_SPD && rate_hi != $past(rate_hi)));

  assert_speed_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (sub_state == S_SPD && !tmo) |=> (sub_state == S_LOCK && $stable(rate_hi)));

  assert_fail_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (sub_state == S_CFG && !tmo && ts_run >= NEED && !ts_spd)
      |=> (sub_state == S_IDLE && $stable(rate_hi)));

  assert_idle_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (sub_state == S_IDLE && idle_seen && !tmo) |=> sub_state == S_ACT);

  assert_timeout_R9: assert property (@(posedge clk) disable iff (rst)
    (sub_state != S_ACT && tmo) |=> sub_state == S_LOCK);

endmodule

// File: tb/sim_link_rate_seq.sv
module sim_link_rate_seq;
  localparam int CNT_W = 4;
  localparam int NEED  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go_fast = 0, sym_lock = 0, ts_spd = 0, idle_seen = 0, tmo = 0;
  logic [CNT_W-1:0] ts_run = '0;
  logic [2:0] sub_state;
  logic rate_hi, send_ts2;

  int n_run = 0, n_fail = 0;

  // model state
  logic [2:0] m_st = 0;
  logic m_rate = 0, m_base = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  link_rate_seq #(.CNT_W(CNT_W), .MATCH_NEED(NEED)) u0 (
    .clk(clk), .rst(rst), .go_fast(go_fast), .sym_lock(sym_lock),
    .ts_run(ts_run), .ts_spd(ts_spd), .idle_seen(idle_seen), .tmo(tmo),
    .sub_state(sub_state), .rate_hi(rate_hi), .send_ts2(send_ts2));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance the model by one edge, return the requirement that governs it
  function automatic string model_step();
    string t;
    if (tmo && m_st != 0) begin
      t = "R9"; m_st = 1; m_rate = m_base; m_pend = 0;
    end else begin
      case (m_st)
        0: begin t = "R2"; if (go_fast) begin m_st = 1; m_base = m_rate; m_pend = 1; end end
        1: begin t = "R3"; if (sym_lock) m_st = 2; end
        2: begin
             if (int'(ts_run) < NEED) t = "R4";
             else if (ts_spd && m_pend) begin t = "R5"; m_st = 3; m_rate = ~m_rate; m_pend = 0; end
             else begin t = "R7"; m_st = 4; m_pend = 0; end
           end
        3: begin t = "R6"; m_st = 1; end
        default: begin t = "R8"; if (idle_seen) m_st = 0; end
      endcase
    end
    return t;
  endfunction

  task automatic step(input logic g, input logic l, input int r, input logic s,
                      input logic i, input logic t);
    string tag;
    go_fast = g; sym_lock = l; ts_run = CNT_W'(r); ts_spd = s; idle_seen = i; tmo = t;
    tag = model_step();
    @(posedge clk); #1;
    chk(tag, sub_state, m_st);
    chk(tag, rate_hi, m_rate);
    chk("R3", send_ts2, (m_st == 2));
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R1", sub_state, 0); chk("R1", rate_hi, 0); chk("R1", send_ts2, 0);

    // R2: other inputs ignored in active
    step(0, 1, 15, 1, 1, 1); chk("R2", sub_state, 0);
    // full upgrade
    step(1, 0, 0, 0, 0, 0); chk("R2", sub_state, 1);
    step(0, 1, 0, 0, 0, 0); chk("R3", send_ts2, 1);
    step(0, 0, 7, 1, 0, 0); chk("R4", sub_state, 2);
    step(0, 0, 8, 1, 0, 0); chk("R5", sub_state, 3); chk("R5", rate_hi, 1);
    step(0, 0, 0, 0, 0, 0); chk("R6", sub_state, 1); chk("R6", rate_hi, 1);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 9, 1, 0, 0); chk("R7", sub_state, 4); chk("R7", rate_hi, 1);
    step(0, 0, 0, 0, 0, 0); chk("R8", sub_state, 4);
    step(0, 0, 0, 0, 1, 0); chk("R8", sub_state, 0);
    // failed negotiation
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 15, 0, 0, 0); chk("R7", sub_state, 4); chk("R7", rate_hi, 1);
    step(0, 0, 0, 0, 1, 0);
    // timeout fallback after switch
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 8, 1, 0, 0); chk("R5", rate_hi, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 1); chk("R9", sub_state, 1); chk("R9", rate_hi, 1);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 8, 1, 0, 0); chk("R9", sub_state, 4);
    step(0, 0, 8, 1, 1, 1); chk("R9", sub_state, 1);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 8, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0); chk("R8", sub_state, 0);

    // sweep
    lf = 16'hACE1;
    for (int k = 0; k < 6000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[1], lf[2], int'(lf[7:4]) | (lf[3] ? 8 : 0), lf[8],
           lf[9] & lf[10], lf[11] & lf[12] & lf[13]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule